// File: doc/BRIEF.md
# Burst-Mode Clocked Serial Port with Slot Buffer

This block is one channel of a synchronous serial interface that exchanges a burst of one to eight bytes with no per-byte help from a controller. Software-side logic loads up to eight bytes into an addressed slot buffer, selects the byte count, and issues a start command. The engine then shifts each byte out and shifts a byte in at the same time. Each incoming byte replaces the outgoing byte in the slot it came from, so one buffer serves both directions of a full-duplex exchange.

The channel runs either as clock master, where it divides the system clock to make the serial clock, or as slave, where it follows a serial clock from outside after synchronising it. An optional chip-select mode gates the whole exchange with an active-low select input. While the select is high, the transfer is held and the clock and data drivers float. When the last byte completes, the busy flag drops and a single-cycle done pulse is raised. That pulse can serve as an interrupt request.

Top module: `fifo_serial_port`

## Requirements
- R1: After reset, busy and done are 0 and both pin drivers are off (sck_oe = 0, so_oe = 0).
- R2: A start while idle transfers len_m1+1 bytes, taking slots 0, 1, … in rising order and leaving higher slots untouched. In master mode without chip-select, busy is high for exactly 16·HALF·(len_m1+1) cycles, counted from the clock edge that captures start.
- R3: In master mode, sck_o rests high, falls HALF cycles after start is captured, and then toggles every HALF cycles (period 2·HALF ≥ 16 system clocks). sck_oe is 1 throughout the transfer.
- R4: Bits leave on so MSB first. so changes only in step with a falling serial-clock edge, and so_oe is 1 during an enabled transfer.
- R5: si is sampled on each rising serial-clock edge, first bit = MSB. The assembled byte is written back into the slot its transmitted byte was read from.
- R6: When the last byte completes, busy falls and done is 1 for exactly that one cycle.
- R7: A start issued while busy is ignored, including its byte count.
- R8: Slot writes (wr_en) issued while busy are ignored.
- R9: With cfg_csmode = 1, a high cs_n (after two synchroniser stages) holds the transfer and forces sck_oe = 0 and so_oe = 0. Driving cs_n low resumes the transfer.
- R10: With cfg_master = 0, sck_oe is never asserted. The shift engine advances on the falling and rising edges of sck_i, which is resynchronised (along with si and cs_n) through two flip-flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 = drive the serial clock, 0 = follow sck_i |
| cfg_csmode | input | 1 | 1 = gate the transfer with cs_n |
| len_m1 | input | 3 | Byte count minus one (0..7) |
| start | input | 1 | Start a burst (accepted only when idle) |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse at burst completion |
| wr_en | input | 1 | Slot write strobe |
| wr_addr | input | 3 | Slot write index |
| wr_data | input | 8 | Slot write data |
| rd_addr | input | 3 | Slot read index |
| rd_data | output | 8 | Slot read data (combinational) |
| sck_i | input | 1 | Serial clock from the pin |
| sck_o | output | 1 | Serial clock to the pin |
| sck_oe | output | 1 | Serial clock driver enable |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Serial data driver enable |
| cs_n | input | 1 | Active-low chip select |

## Verification
Most internal faults in this block show up on the pins within one serial-clock half period. A slip in the divider or a wrong phase level changes sck_o on the very next expected toggle. A wrong bit pointer or a wrong load puts the wrong level on so at the next falling edge. A fault in the slot index or in the final-byte compare moves the fall of busy and the done pulse by whole byte times, and the comparison against the reference catches that in the cycle it happens. Write-back faults only appear when the slots are read after the burst. A broken chip-select gate shows up at once as an enabled driver or as a clock that moves while cs_n is high.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

  // Serial-clock edge events seen by the shift engine in one system cycle.
  typedef struct packed {
    logic fall;
    logic rise;
  } sfp_evt_t;

endpackage

// File: rtl/sfp_sync.sv
module sfp_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      stab_q <= RST_VAL;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;

endmodule

// File: rtl/sfp_clkgen.sv
module sfp_clkgen
  import sfp_pkg::*;
#(
  parameter int HALF = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  logic     clr,
  output sfp_evt_t evt,
  output logic     sck
);

  localparam int CW = $clog2(HALF + 1);

  logic [CW-1:0] hc_q, hc_d;
  logic          sck_q, sck_d;
  logic          tick;

  assign tick = run && (hc_q == CW'(HALF - 1));

  always_comb begin
    hc_d  = hc_q;
    sck_d = sck_q;
    if (clr) begin
      hc_d  = '0;
      sck_d = 1'b1;
    end else if (run) begin
      if (tick) begin
        hc_d  = '0;
        sck_d = !sck_q;
      end else begin
        hc_d = hc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc_q  <= '0;
      sck_q <= 1'b1;
    end else begin
      hc_q  <= hc_d;
      sck_q <= sck_d;
    end
  end

  assign evt.fall = tick && sck_q;
  assign evt.rise = tick && !sck_q;
  assign sck      = sck_q;

endmodule

// File: rtl/sfp_shifter.sv
module sfp_shifter
  import sfp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  sfp_evt_t      evt,
  input  logic [DW-1:0] ld_data,
  input  logic          si,
  output logic          so,
  output logic [DW-1:0] rx_data,
  output logic          byte_done
);

  localparam int BW = $clog2(DW);
  localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

  logic [DW-1:0] sr_q, sr_d;
  logic          samp_q, samp_d;
  logic [BW-1:0] bc_q, bc_d;

  always_comb begin
    sr_d   = sr_q;
    samp_d = samp_q;
    bc_d   = bc_q;
    if (clr) begin
      bc_d = '0;
    end else begin
      if (evt.fall) begin
        sr_d = (bc_q == '0) ? ld_data : {sr_q[DW-2:0], samp_q};
      end
      if (evt.rise) begin
        samp_d = si;
        bc_d   = (bc_q == LAST_BIT) ? '0 : bc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      samp_q <= 1'b0;
      bc_q   <= '0;
    end else begin
      sr_q   <= sr_d;
      samp_q <= samp_d;
      bc_q   <= bc_d;
    end
  end

  assign so        = sr_q[DW-1];
  assign rx_data   = {sr_q[DW-2:0], si};
  assign byte_done = !clr && evt.rise && (bc_q == LAST_BIT);

endmodule

// File: rtl/sfp_slots.sv
module sfp_slots #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_en,
  input  logic [AW-1:0] hw_addr,
  input  logic [DW-1:0] hw_data,
  input  logic          ew_en,
  input  logic [AW-1:0] ew_addr,
  input  logic [DW-1:0] ew_data,
  input  logic [AW-1:0] hr_addr,
  output logic [DW-1:0] hr_data,
  input  logic [AW-1:0] er_addr,
  output logic [DW-1:0] er_data
);

  logic [DW-1:0] slot_v [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [DW-1:0] q;
    logic          hsel, esel;

    assign hsel = hw_en && (hw_addr == AW'(i));
    assign esel = ew_en && (ew_addr == AW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (hsel) begin
        q <= hw_data;
      end else if (esel) begin
        q <= ew_data;
      end
    end

    assign slot_v[i] = q;
  end

  assign hr_data = slot_v[hr_addr];
  assign er_data = slot_v[er_addr];

endmodule

// File: rtl/fifo_serial_port.sv
module fifo_serial_port
  import sfp_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  parameter int HALF  = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_master,
  input  logic          cfg_csmode,
  input  logic [AW-1:0] len_m1,
  input  logic          start,
  output logic          busy,
  output logic          done,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          sck_i,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          si,
  output logic          so,
  output logic          so_oe,
  input  logic          cs_n
);

  // Pin synchronisers: {sck_i, cs_n, si}
  logic [2:0] pin_s;
  logic       sck_s, cs_s, si_s;

  sfp_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sck_i, cs_n, si}),
    .q     (pin_s)
  );

  assign sck_s = pin_s[2];
  assign cs_s  = pin_s[1];
  assign si_s  = pin_s[0];

  // Sequencer state
  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [AW-1:0] idx_q, idx_d;
  logic [AW-1:0] last_q, last_d;
  logic          sckp_q;

  logic          cs_ok, run;
  sfp_evt_t      m_evt, s_evt, evt;
  logic          m_sck;
  logic          sh_si, byte_done;
  logic [DW-1:0] ld_data, rx_data;

  assign cs_ok = !cfg_csmode || !cs_s;
  assign run   = busy_q && cs_ok;

  sfp_clkgen #(.HALF(HALF)) u_clkgen (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run && cfg_master),
    .clr   (!busy_q),
    .evt   (m_evt),
    .sck   (m_sck)
  );

  // Slave-side edge detection on the synchronised clock
  assign s_evt.fall = run && !cfg_master && sckp_q && !sck_s;
  assign s_evt.rise = run && !cfg_master && !sckp_q && sck_s;

  assign evt   = cfg_master ? m_evt : s_evt;
  assign sh_si = cfg_master ? si : si_s;

  sfp_shifter #(.DW(DW)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (!busy_q),
    .evt       (evt),
    .ld_data   (ld_data),
    .si        (sh_si),
    .so        (so),
    .rx_data   (rx_data),
    .byte_done (byte_done)
  );

  sfp_slots #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_slots (
    .clk     (clk),
    .rst_n   (rst_n),
    .hw_en   (wr_en && !busy_q),
    .hw_addr (wr_addr),
    .hw_data (wr_data),
    .ew_en   (busy_q && byte_done),
    .ew_addr (idx_q),
    .ew_data (rx_data),
    .hr_addr (rd_addr),
    .hr_data (rd_data),
    .er_addr (idx_q),
    .er_data (ld_data)
  );

  // Sequencer next state
  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    idx_d  = idx_q;
    last_d = last_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        idx_d  = '0;
        last_d = len_m1;
      end
    end else if (byte_done) begin
      if (idx_q == last_q) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
      sckp_q <= 1'b1;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      idx_q  <= idx_d;
      last_q <= last_d;
      sckp_q <= sck_s;
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign sck_o  = cfg_master ? m_sck : 1'b1;
  assign sck_oe = busy_q && cfg_master && cs_ok;
  assign so_oe  = busy_q && cs_ok;

endmodule

// File: rtl/sfp_checker.sv
module sfp_checker #(
  parameter int HALF = 8
) (
  input logic clk,
  input logic rst_n,
  input logic cfg_master,
  input logic cfg_csmode,
  input logic cs_n,
  input logic busy,
  input logic done,
  input logic sck_o,
  input logic sck_oe,
  input logic so_oe
);

  logic [15:0] since_q;
  logic        sckp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      sckp_q  <= 1'b1;
    end else begin
      sckp_q <= sck_o;
      if (!busy)                  since_q <= '0;
      else if (sck_o != sckp_q)   since_q <= 16'd1;
      else if (since_q != 16'hFFFF) since_q <= since_q + 16'd1;
    end
  end

  // R1: drivers stay off while idle
  assert_idle_float_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sck_oe && !so_oe));

  // R3: master clock toggles exactly every HALF cycles
  assert_half_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && !cfg_csmode && busy && (sck_o != sckp_q)) |-> (since_q == 16'(HALF)));

  // R6: done is a single-cycle pulse marking the fall of busy
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_busy_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R9: select high (two stages ago) floats both drivers
  assert_cs_float_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_csmode && $past(cs_n, 2)) |-> (!sck_oe && !so_oe));

  // R10: slave never drives the clock
  assert_slave_noclk_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_master |-> !sck_oe);

endmodule

bind fifo_serial_port sfp_checker #(.HALF(HALF)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_master (cfg_master),
  .cfg_csmode (cfg_csmode),
  .cs_n       (cs_n),
  .busy       (busy),
  .done       (done),
  .sck_o      (sck_o),
  .sck_oe     (sck_oe),
  .so_oe      (so_oe)
);

// File: tb/sim_fifo_serial_port.sv
`timescale 1ns/100ps
module sim_fifo_serial_port;

  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_master = 1'b1, cfg_csmode = 1'b0;
  logic [2:0] len_m1 = '0;
  logic       start = 1'b0;
  logic       busy, done;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic       sck_i = 1'b1, sck_o, sck_oe;
  logic       si = 1'b0, so, so_oe;
  logic       cs_n = 1'b1;

  int n_chk = 0, n_err = 0;
  bit [7:0] txq [8];
  bit [7:0] rxq [8];

  always #2.5 clk = !clk;

  fifo_serial_port u0 (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_csmode(cfg_csmode),
    .len_m1(len_m1), .start(start), .busy(busy), .done(done),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .si(si), .so(so), .so_oe(so_oe), .cs_n(cs_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic put_slot(input int a, input bit [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look_slot(input int a, input bit [7:0] exp, input string req);
    @(negedge clk);
    rd_addr = 3'(a);
    #1;
    chk(rd_data == exp, req, "slot contents", rd_data, exp);
  endtask

  // Cycle-by-cycle reference for a master burst without chip-select.
  task automatic run_master(input int n, input int restart_at, input int poke_at);
    int total;
    int m;
    total = 16 * H * n;
    @(negedge clk);
    len_m1 = 3'(n - 1); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int e = 0; e <= total; e++) begin
      if (e > 0) @(negedge clk);
      m = e / H;
      chk(busy == (e < total), "R2", "busy window", busy, e < total);
      chk(done == (e == total), "R6", "done pulse", done, e == total);
      if (e < total) begin
        chk(sck_o == (m % 2 == 0), "R3", "sck level", sck_o, m % 2 == 0);
        chk(sck_oe == 1'b1, "R3", "sck_oe", sck_oe, 1);
        chk(so_oe == 1'b1, "R4", "so_oe", so_oe, 1);
        if (m >= 1)
          chk(so == txq[(m - 1) / 16][7 - (((m - 1) / 2) % 8)], "R4", "so bit",
              so, txq[(m - 1) / 16][7 - (((m - 1) / 2) % 8)]);
        if (m % 2 == 1) si = rxq[(m - 1) / 16][7 - (((m - 1) / 2) % 8)];
      end else begin
        chk(sck_oe == 1'b0 && so_oe == 1'b0, "R1", "drivers off after burst",
            {sck_oe, so_oe}, 0);
      end
      if (e == restart_at) begin start = 1'b1; len_m1 = 3'd0; end
      else start = 1'b0;
      if (e == poke_at) begin wr_en = 1'b1; wr_addr = 3'd7; wr_data = 8'h3C; end
      else wr_en = 1'b0;
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    bit seen;
    int gap;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0, "R1", "busy at reset", busy, 0);
    chk(done == 1'b0, "R1", "done at reset", done, 0);
    chk(sck_oe == 1'b0, "R1", "sck_oe at reset", sck_oe, 0);
    chk(so_oe == 1'b0, "R1", "so_oe at reset", so_oe, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(sck_oe == 1'b0 && so_oe == 1'b0, "R1", "drivers after release", {sck_oe, so_oe}, 0);

    // T1: three-byte master burst, slot 3 must survive (R2, R5)
    txq[0] = 8'hA5; txq[1] = 8'h3C; txq[2] = 8'h81;
    rxq[0] = 8'h5A; rxq[1] = 8'hC3; rxq[2] = 8'h7E;
    for (int i = 0; i < 3; i++) put_slot(i, txq[i]);
    put_slot(3, 8'h99);
    run_master(3, -1, -1);
    for (int i = 0; i < 3; i++) look_slot(i, rxq[i], "R5");
    look_slot(3, 8'h99, "R2");

    // T2: full eight-byte burst with an ignored restart (R7)
    for (int i = 0; i < 8; i++) begin
      txq[i] = 8'(i * 37 + 5);
      rxq[i] = ~txq[i];
      put_slot(i, txq[i]);
    end
    run_master(8, 100, -1);
    for (int i = 0; i < 8; i++) look_slot(i, rxq[i], "R7");

    // T3: single byte; write to slot 7 during the burst is dropped (R8)
    txq[0] = 8'h01; rxq[0] = 8'h80;
    put_slot(0, txq[0]);
    put_slot(7, 8'hC3);
    run_master(1, -1, 30);
    look_slot(0, rxq[0], "R5");
    look_slot(7, 8'hC3, "R8");

    // T4: master in chip-select mode, held while cs_n high (R9)
    cfg_csmode = 1'b1; cs_n = 1'b1; si = 1'b1;
    put_slot(0, 8'h5A);
    @(negedge clk); len_m1 = 3'd0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    seen = 1'b0;
    repeat (40) begin
      @(negedge clk);
      if (sck_oe || so_oe || !sck_o) seen = 1'b1;
    end
    chk(!seen, "R9", "drivers or clock active while deselected", seen, 0);
    chk(busy == 1'b1, "R9", "burst held", busy, 1);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(sck_oe == 1'b1 && so_oe == 1'b1, "R9", "drivers after select", {sck_oe, so_oe}, 3);
    seen = 1'b0;
    for (int k = 0; k < 400 && !seen; k++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    chk(seen, "R9", "burst completes after select", seen, 1);
    look_slot(0, 8'hFF, "R5");

    // T5: slave mode with chip-select (R10, R4, R5, R9)
    cfg_master = 1'b0; cs_n = 1'b1; sck_i = 1'b1;
    txq[0] = 8'hC6; txq[1] = 8'h2B; rxq[0] = 8'h93; rxq[1] = 8'h4D;
    put_slot(0, txq[0]); put_slot(1, txq[1]);
    @(negedge clk); len_m1 = 3'd1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    chk(busy == 1'b1 && so_oe == 1'b0, "R9", "slave so floats while deselected",
        {busy, so_oe}, 2);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(so_oe == 1'b1, "R9", "slave so driven when selected", so_oe, 1);
    seen = 1'b0; gap = 0;
    for (int j = 0; j < 2; j++) begin
      for (int b = 0; b < 8; b++) begin
        @(negedge clk);
        sck_i = 1'b0; si = rxq[j][7 - b];
        repeat (10) begin
          @(negedge clk);
          if (sck_oe) gap++;
        end
        chk(so == txq[j][7 - b], "R10", "slave so bit", so, txq[j][7 - b]);
        sck_i = 1'b1;
        repeat (10) begin
          @(negedge clk);
          if (sck_oe) gap++;
          if (done) seen = 1'b1;
        end
      end
    end
    chk(gap == 0, "R10", "sck_oe in slave mode", gap, 0);
    chk(seen, "R10", "slave burst done", seen, 1);
    chk(busy == 1'b0, "R6", "busy after slave burst", busy, 0);
    look_slot(0, rxq[0], "R5");
    look_slot(1, rxq[1], "R5");

    summary();
  end

endmodule